// File: doc/BRIEF.md
# Dual-Port Word Memory with Mailbox Interrupts

This block is a word memory shared by two independent ports, called left and right. Each port selects the block, picks read or write, enables its output, and chooses one or both byte lanes of a two-lane word. All activity is synchronous to one clock. Write data lands at the clock edge. Read data and a valid flag are registered, so they appear one cycle after the request.

The two highest word addresses also serve as mailboxes between the ports. The top word belongs to the right port and the word just below it belongs to the left port. When one port writes into the other's mailbox, the owner's active-low interrupt is asserted. The owner removes the interrupt by reading its own mailbox. Each port also receives a busy input from an external arbiter. While a port's busy input is high, that port can neither raise the peer's interrupt nor clear its own, although its memory traffic still proceeds.

The expected use is message passing between two processors: the sender deposits a word, and the receiver takes the interrupt, reads the word and so acknowledges it.

Top module: `dpram_mailbox`

## Requirements
- R1: During reset and right after it, both interrupt outputs are high (deasserted) and both read-valid outputs are low.
- R2: A write happens when the port's select and write inputs are high and at least one lane enable is high. Only the lanes enabled are updated: the upper lane enable covers bits [15:8] and the lower lane enable covers bits [7:0]. A port whose select is low, or whose two lane enables are both low, changes nothing.
- R3: A read needs select, write low, output enable and at least one lane enable. The cycle after such a request, read-valid is 1, enabled lanes carry the stored data and disabled lanes carry zero. After any other request, read-valid is 0 and the read data is all zero.
- R4: A write by the right port to address 2^AW-2 drives the left interrupt low in the next cycle. A write by the left port to address 2^AW-1 drives the right interrupt low in the next cycle.
- R5: A read by a port of its own mailbox releases that port's interrupt (to high) in the next cycle. The left mailbox is 2^AW-2 and the right mailbox is 2^AW-1.
- R6: A port that reads the other port's mailbox leaves the other port's interrupt unchanged.
- R7: While a port's busy input is high, its write into the other port's mailbox does not assert the other interrupt.
- R8: While a port's busy input is high, its read of its own mailbox does not release its interrupt.
- R9: If a port reads its own mailbox in the same cycle as the other port writes into it, and both busy inputs are low, the interrupt is asserted (or stays asserted) in the next cycle.
- R10: If one port writes a word in the same cycle as the other port reads it, the read returns the old contents. If both ports write the same lane of a word in one cycle, the left port's data is kept.
- R11: A port writing its own mailbox, or any access to a non-mailbox address, leaves both interrupts unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| l_sel | input | 1 | Left port select |
| l_wr | input | 1 | Left port: 1 write, 0 read |
| l_oe | input | 1 | Left port output enable |
| l_hi | input | 1 | Left port upper lane enable |
| l_lo | input | 1 | Left port lower lane enable |
| l_hold | input | 1 | Left port busy from arbiter |
| l_addr | input | AW | Left port word address |
| l_wdata | input | 16 | Left port write data |
| l_rdata | output | 16 | Left port read data |
| l_rvalid | output | 1 | Left port read data valid |
| l_irq_n | output | 1 | Left port interrupt, active low |
| r_sel | input | 1 | Right port select |
| r_wr | input | 1 | Right port: 1 write, 0 read |
| r_oe | input | 1 | Right port output enable |
| r_hi | input | 1 | Right port upper lane enable |
| r_lo | input | 1 | Right port lower lane enable |
| r_hold | input | 1 | Right port busy from arbiter |
| r_addr | input | AW | Right port word address |
| r_wdata | input | 16 | Right port write data |
| r_rdata | output | 16 | Right port read data |
| r_rvalid | output | 1 | Right port read data valid |
| r_irq_n | output | 1 | Right port interrupt, active low |

## Verification
The owner's read of its own mailbox, which clears the interrupt, can fall in the same cycle as the peer's write to that mailbox, which sets it. The bench provokes this on both sides by driving the two ports together in one cycle. It expects the interrupt to remain asserted and the read to return the word that was stored before the write. A second collision, two writes to one word in the same cycle, is judged by reading the word back and looking for the left port's data.

// File: rtl/dpmbx_pkg.sv
package dpmbx_pkg;
  // two byte lanes per word: index 1 = upper, index 0 = lower
  localparam int LANES = 2;

  typedef struct packed {
    logic             wr_go;      // write accepted
    logic             rd_go;      // read accepted
    logic [LANES-1:0] lanes;      // lane enables
    logic             raise_peer; // unheld write into peer mailbox
    logic             clear_own;  // unheld read of own mailbox
  } port_req_t;
endpackage

// File: rtl/dpmbx_port.sv
module dpmbx_port
  import dpmbx_pkg::*;
#(
  parameter int AW       = 8,
  parameter int OWN_MBX  = 254,
  parameter int PEER_MBX = 255
) (
  input  logic          sel,
  input  logic          wr,
  input  logic          oe,
  input  logic          hi,
  input  logic          lo,
  input  logic          hold,
  input  logic [AW-1:0] addr,
  output port_req_t     req
);
  localparam logic [AW-1:0] OWN_A  = AW'(OWN_MBX);
  localparam logic [AW-1:0] PEER_A = AW'(PEER_MBX);

  logic access;

  always_comb begin
    access         = sel && (hi || lo);
    req.lanes      = {hi, lo};
    req.wr_go      = access && wr;
    req.rd_go      = access && !wr && oe;
    req.raise_peer = req.wr_go && (addr == PEER_A) && !hold;
    req.clear_own  = req.rd_go && (addr == OWN_A) && !hold;
  end
endmodule

// File: rtl/dpmbx_flag.sv
module dpmbx_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic flag_n
);
  logic act_q, act_d;

  // set has priority over clear
  always_comb begin
    act_d = act_q;
    if (clr) act_d = 1'b0;
    if (set) act_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) act_q <= 1'b0;
    else        act_q <= act_d;
  end

  assign flag_n = !act_q;
endmodule

// File: rtl/dpmbx_store.sv
module dpmbx_store
  import dpmbx_pkg::*;
#(
  parameter int AW     = 8,
  parameter int LANE_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  port_req_t               a_req,
  input  logic [AW-1:0]           a_addr,
  input  logic [LANES*LANE_W-1:0] a_wdata,
  output logic [LANES*LANE_W-1:0] a_rdata,
  output logic                    a_rvalid,
  input  port_req_t               b_req,
  input  logic [AW-1:0]           b_addr,
  input  logic [LANES*LANE_W-1:0] b_wdata,
  output logic [LANES*LANE_W-1:0] b_rdata,
  output logic                    b_rvalid
);
  localparam int DEPTH = 1 << AW;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    logic [LANE_W-1:0] a_d, b_d, a_q, b_q;

    // port a is written last, so it wins a same-word collision
    always_ff @(posedge clk) begin
      if (b_req.wr_go && b_req.lanes[g]) mem[b_addr] <= b_wdata[g*LANE_W +: LANE_W];
      if (a_req.wr_go && a_req.lanes[g]) mem[a_addr] <= a_wdata[g*LANE_W +: LANE_W];
    end

    always_comb begin
      a_d = (a_req.rd_go && a_req.lanes[g]) ? mem[a_addr] : '0;
      b_d = (b_req.rd_go && b_req.lanes[g]) ? mem[b_addr] : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        a_q <= '0;
        b_q <= '0;
      end else begin
        a_q <= a_d;
        b_q <= b_d;
      end
    end

    assign a_rdata[g*LANE_W +: LANE_W] = a_q;
    assign b_rdata[g*LANE_W +: LANE_W] = b_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_rvalid <= 1'b0;
      b_rvalid <= 1'b0;
    end else begin
      a_rvalid <= a_req.rd_go;
      b_rvalid <= b_req.rd_go;
    end
  end
endmodule

// File: rtl/dpram_mailbox.sv
module dpram_mailbox
  import dpmbx_pkg::*;
#(
  parameter int AW     = 8,
  parameter int LANE_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    l_sel,
  input  logic                    l_wr,
  input  logic                    l_oe,
  input  logic                    l_hi,
  input  logic                    l_lo,
  input  logic                    l_hold,
  input  logic [AW-1:0]           l_addr,
  input  logic [LANES*LANE_W-1:0] l_wdata,
  output logic [LANES*LANE_W-1:0] l_rdata,
  output logic                    l_rvalid,
  output logic                    l_irq_n,
  input  logic                    r_sel,
  input  logic                    r_wr,
  input  logic                    r_oe,
  input  logic                    r_hi,
  input  logic                    r_lo,
  input  logic                    r_hold,
  input  logic [AW-1:0]           r_addr,
  input  logic [LANES*LANE_W-1:0] r_wdata,
  output logic [LANES*LANE_W-1:0] r_rdata,
  output logic                    r_rvalid,
  output logic                    r_irq_n
);
  localparam int DEPTH  = 1 << AW;
  localparam int R_MBX  = DEPTH - 1;
  localparam int L_MBX  = DEPTH - 2;

  // reset synchronizer: asserts at once, releases on the clock
  logic [1:0] rst_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_sync_n = rst_q[1];

  port_req_t l_req, r_req;

  dpmbx_port #(.AW(AW), .OWN_MBX(L_MBX), .PEER_MBX(R_MBX)) u_lport (
    .sel(l_sel), .wr(l_wr), .oe(l_oe), .hi(l_hi), .lo(l_lo),
    .hold(l_hold), .addr(l_addr), .req(l_req)
  );

  dpmbx_port #(.AW(AW), .OWN_MBX(R_MBX), .PEER_MBX(L_MBX)) u_rport (
    .sel(r_sel), .wr(r_wr), .oe(r_oe), .hi(r_hi), .lo(r_lo),
    .hold(r_hold), .addr(r_addr), .req(r_req)
  );

  dpmbx_store #(.AW(AW), .LANE_W(LANE_W)) u_store (
    .clk(clk), .rst_n(rst_sync_n),
    .a_req(l_req), .a_addr(l_addr), .a_wdata(l_wdata),
    .a_rdata(l_rdata), .a_rvalid(l_rvalid),
    .b_req(r_req), .b_addr(r_addr), .b_wdata(r_wdata),
    .b_rdata(r_rdata), .b_rvalid(r_rvalid)
  );

  dpmbx_flag u_lflag (
    .clk(clk), .rst_n(rst_sync_n),
    .set(r_req.raise_peer), .clr(l_req.clear_own), .flag_n(l_irq_n)
  );

  dpmbx_flag u_rflag (
    .clk(clk), .rst_n(rst_sync_n),
    .set(l_req.raise_peer), .clr(r_req.clear_own), .flag_n(r_irq_n)
  );
endmodule

// File: rtl/dpmbx_chk.sv
module dpmbx_chk #(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          l_sel, l_wr, l_oe, l_hi, l_lo, l_hold,
  input logic [AW-1:0] l_addr,
  input logic          r_sel, r_wr, r_oe, r_hi, r_lo, r_hold,
  input logic [AW-1:0] r_addr,
  input logic [DW-1:0] l_rdata,
  input logic          l_rvalid, l_irq_n, r_rvalid, r_irq_n
);
  localparam logic [AW-1:0] RMB = {AW{1'b1}};
  localparam logic [AW-1:0] LMB = {{(AW-1){1'b1}}, 1'b0};

  logic l_rd, r_rd, l_raise, r_raise, l_own_rd, r_own_rd;
  assign l_rd     = l_sel && !l_wr && l_oe && (l_hi || l_lo);
  assign r_rd     = r_sel && !r_wr && r_oe && (r_hi || r_lo);
  assign r_raise  = r_sel && r_wr && (r_hi || r_lo) && r_addr == LMB && !r_hold;
  assign l_raise  = l_sel && l_wr && (l_hi || l_lo) && l_addr == RMB && !l_hold;
  assign l_own_rd = l_rd && l_addr == LMB && !l_hold;
  assign r_own_rd = r_rd && r_addr == RMB && !r_hold;

  // R4
  lirq_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    r_raise |=> !l_irq_n);
  // R4
  rirq_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    l_raise |=> !r_irq_n);
  // R7
  lirq_norise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    l_irq_n && !r_raise |=> l_irq_n);
  // R7
  rirq_norise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    r_irq_n && !l_raise |=> r_irq_n);
  // R5
  lirq_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    l_own_rd && !r_raise |=> l_irq_n);
  // R6
  rirq_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !r_irq_n && !r_own_rd |=> !r_irq_n);
  // R8
  lirq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !l_irq_n && l_hold |=> !l_irq_n);
  // R3
  lrd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !l_rd |=> !l_rvalid && l_rdata == '0);
  // R3
  rrd_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
    r_rd |=> r_rvalid);
endmodule

bind dpram_mailbox dpmbx_chk #(.AW(AW), .DW(2*LANE_W)) u_chk (
  .clk(clk), .rst_n(rst_sync_n),
  .l_sel(l_sel), .l_wr(l_wr), .l_oe(l_oe), .l_hi(l_hi), .l_lo(l_lo), .l_hold(l_hold),
  .l_addr(l_addr),
  .r_sel(r_sel), .r_wr(r_wr), .r_oe(r_oe), .r_hi(r_hi), .r_lo(r_lo), .r_hold(r_hold),
  .r_addr(r_addr),
  .l_rdata(l_rdata), .l_rvalid(l_rvalid), .l_irq_n(l_irq_n),
  .r_rvalid(r_rvalid), .r_irq_n(r_irq_n)
);

// File: tb/dpram_mailbox_test.sv
module dpram_mailbox_test;
  localparam int AW    = 8;
  localparam int DW    = 16;
  localparam int DEPTH = 1 << AW;
  localparam logic [AW-1:0] RMBX = AW'(DEPTH - 1);
  localparam logic [AW-1:0] LMBX = AW'(DEPTH - 2);

  logic clk = 1'b0;
  logic rst_n;
  logic l_sel, l_wr, l_oe, l_hi, l_lo, l_hold;
  logic r_sel, r_wr, r_oe, r_hi, r_lo, r_hold;
  logic [AW-1:0] l_addr, r_addr;
  logic [DW-1:0] l_wdata, r_wdata, l_rdata, r_rdata;
  logic l_rvalid, r_rvalid, l_irq_n, r_irq_n;

  always #5 clk = ~clk;

  dpram_mailbox uut (.*);

  // ---------------- behavioural reference ----------------
  logic [DW-1:0] mmem [DEPTH];
  bit   [1:0]    mknown [DEPTH];
  bit            m_lirq_n, m_rirq_n, m_lval, m_rval;
  logic [DW-1:0] m_ldat, m_rdat;
  bit   [1:0]    m_lmask, m_rmask;
  bit            lw, lr, rw, rr;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_lirq_n = 1; m_rirq_n = 1; m_lval = 0; m_rval = 0;
      m_ldat = 0; m_rdat = 0; m_lmask = 2'b11; m_rmask = 2'b11;
    end else begin
      lw = l_sel && (l_hi || l_lo) && l_wr;
      lr = l_sel && (l_hi || l_lo) && !l_wr && l_oe;
      rw = r_sel && (r_hi || r_lo) && r_wr;
      rr = r_sel && (r_hi || r_lo) && !r_wr && r_oe;
      // reads see the contents before this cycle's writes
      m_lval = lr; m_ldat = 0; m_lmask = 2'b11;
      m_rval = rr; m_rdat = 0; m_rmask = 2'b11;
      if (lr) begin
        if (l_hi) begin m_ldat[15:8] = mmem[l_addr][15:8]; m_lmask[1] = mknown[l_addr][1]; end
        if (l_lo) begin m_ldat[7:0]  = mmem[l_addr][7:0];  m_lmask[0] = mknown[l_addr][0]; end
      end
      if (rr) begin
        if (r_hi) begin m_rdat[15:8] = mmem[r_addr][15:8]; m_rmask[1] = mknown[r_addr][1]; end
        if (r_lo) begin m_rdat[7:0]  = mmem[r_addr][7:0];  m_rmask[0] = mknown[r_addr][0]; end
      end
      // interrupts: set beats clear
      if (rw && r_addr == LMBX && !r_hold)      m_lirq_n = 0;
      else if (lr && l_addr == LMBX && !l_hold) m_lirq_n = 1;
      if (lw && l_addr == RMBX && !l_hold)      m_rirq_n = 0;
      else if (rr && r_addr == RMBX && !r_hold) m_rirq_n = 1;
      // writes: right first, left last so left wins
      if (rw) begin
        if (r_hi) begin mmem[r_addr][15:8] = r_wdata[15:8]; mknown[r_addr][1] = 1; end
        if (r_lo) begin mmem[r_addr][7:0]  = r_wdata[7:0];  mknown[r_addr][0] = 1; end
      end
      if (lw) begin
        if (l_hi) begin mmem[l_addr][15:8] = l_wdata[15:8]; mknown[l_addr][1] = 1; end
        if (l_lo) begin mmem[l_addr][7:0]  = l_wdata[7:0];  mknown[l_addr][0] = 1; end
      end
    end
  end

  // ---------------- comparison ----------------
  int    checks = 0;
  int    fails  = 0;
  bit    chk_on = 0;
  string cur_req = "R1";

  task automatic check(string what, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h at %0t", cur_req, what, act, exp, $time);
    end
  endtask

  function automatic logic [DW-1:0] lane_mask(bit [1:0] m);
    return {{8{m[1]}}, {8{m[0]}}};
  endfunction

  always @(negedge clk) begin
    if (chk_on) begin
      check("left irq_n",   DW'(l_irq_n),  DW'(m_lirq_n));
      check("right irq_n",  DW'(r_irq_n),  DW'(m_rirq_n));
      check("left rvalid",  DW'(l_rvalid), DW'(m_lval));
      check("right rvalid", DW'(r_rvalid), DW'(m_rval));
      check("left rdata",  l_rdata & lane_mask(m_lmask), m_ldat & lane_mask(m_lmask));
      check("right rdata", r_rdata & lane_mask(m_rmask), r_rdata === r_rdata ? m_rdat & lane_mask(m_rmask) : 'x);
    end
  end

  // ---------------- stimulus ----------------
  task automatic drv_l(bit sel, bit wr, bit oe, bit hi, bit lo,
                       logic [AW-1:0] a, logic [DW-1:0] d, bit hold);
    l_sel = sel; l_wr = wr; l_oe = oe; l_hi = hi; l_lo = lo;
    l_addr = a; l_wdata = d; l_hold = hold;
  endtask

  task automatic drv_r(bit sel, bit wr, bit oe, bit hi, bit lo,
                       logic [AW-1:0] a, logic [DW-1:0] d, bit hold);
    r_sel = sel; r_wr = wr; r_oe = oe; r_hi = hi; r_lo = lo;
    r_addr = a; r_wdata = d; r_hold = hold;
  endtask

  task automatic idle();
    drv_l(0, 0, 0, 0, 0, '0, '0, 0);
    drv_r(0, 0, 0, 0, 0, '0, '0, 0);
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) mknown[i] = 2'b00;
    idle();
    rst_n = 1'b1;
    #2 rst_n = 1'b0;
    #1 chk_on = 1;
    cur_req = "R1";                                   // reset state
    step(3);
    rst_n = 1'b1;
    step(4);

    cur_req = "R2";                                   // full and partial writes
    drv_l(1, 1, 0, 1, 1, 8'd5, 16'hA55A, 0); step(1);
    idle(); cur_req = "R3";
    drv_l(1, 0, 1, 1, 1, 8'd5, '0, 0);
    drv_r(1, 0, 1, 1, 1, 8'd5, '0, 0); step(1);
    cur_req = "R2";
    drv_l(1, 1, 0, 1, 0, 8'd5, 16'h1234, 0);          // upper lane only
    drv_r(1, 1, 0, 0, 1, 8'd6, 16'h9977, 0); step(1); // lower lane only
    drv_l(1, 1, 0, 0, 0, 8'd5, 16'hFFFF, 0);          // no lanes
    drv_r(0, 1, 0, 1, 1, 8'd5, 16'hEEEE, 0); step(1); // not selected
    drv_l(1, 0, 1, 1, 1, 8'd5, '0, 0);
    drv_r(1, 0, 1, 1, 1, 8'd6, '0, 0); step(1);
    cur_req = "R3";
    drv_l(1, 0, 0, 1, 1, 8'd5, '0, 0);                // output enable low
    drv_r(1, 0, 1, 1, 0, 8'd5, '0, 0); step(1);       // upper lane read
    drv_l(1, 0, 1, 0, 1, 8'd5, '0, 0);                // lower lane read
    drv_r(0, 0, 1, 1, 1, 8'd5, '0, 0); step(1);
    idle(); step(1);

    cur_req = "R10";                                  // collisions
    drv_l(1, 1, 0, 1, 1, 8'd9, 16'h1111, 0); step(1);
    drv_l(1, 1, 0, 1, 1, 8'd9, 16'h2222, 0);
    drv_r(1, 0, 1, 1, 1, 8'd9, '0, 0); step(1);
    idle(); drv_r(1, 0, 1, 1, 1, 8'd9, '0, 0); step(1);
    drv_l(1, 1, 0, 1, 1, 8'd10, 16'h3333, 0);
    drv_r(1, 1, 0, 1, 1, 8'd10, 16'h4444, 0); step(1);
    idle(); drv_r(1, 0, 1, 1, 1, 8'd10, '0, 0); step(1);
    idle(); step(1);

    cur_req = "R4";
    drv_r(1, 1, 0, 1, 1, LMBX, 16'hC0DE, 0); step(1);
    idle(); cur_req = "R6";
    drv_r(1, 0, 1, 1, 1, LMBX, '0, 0); step(1);       // peer reads left box
    idle(); cur_req = "R8";
    drv_l(1, 0, 1, 1, 1, LMBX, '0, 1); step(1);       // owner read while busy
    idle(); step(1);
    cur_req = "R5";
    drv_l(1, 0, 1, 0, 1, LMBX, '0, 0); step(1);
    idle(); step(1);
    cur_req = "R7";
    drv_r(1, 1, 0, 1, 1, LMBX, 16'hBEEF, 1); step(1);
    idle(); step(1);
    cur_req = "R11";
    drv_l(1, 1, 0, 1, 1, LMBX, 16'h0101, 0);
    drv_r(1, 1, 0, 1, 1, RMBX, 16'h0202, 0); step(1);
    drv_l(1, 1, 0, 1, 1, 8'd3, 16'h0303, 0);
    drv_r(1, 0, 1, 1, 1, 8'd3, '0, 0); step(1);
    idle(); step(1);

    cur_req = "R4";
    drv_l(1, 1, 0, 0, 1, RMBX, 16'h00AB, 0); step(1);
    idle(); cur_req = "R6";
    drv_l(1, 0, 1, 1, 1, RMBX, '0, 0); step(1);
    idle(); cur_req = "R9";
    drv_l(1, 1, 0, 1, 1, RMBX, 16'h5151, 0);
    drv_r(1, 0, 1, 1, 1, RMBX, '0, 0); step(1);
    idle(); cur_req = "R8";
    drv_r(1, 0, 1, 1, 1, RMBX, '0, 1); step(1);
    idle(); cur_req = "R5";
    drv_r(1, 0, 1, 1, 1, RMBX, '0, 0); step(1);
    idle(); step(1);

    cur_req = "R9";                                   // left side: set and clear together
    drv_l(1, 0, 1, 1, 1, LMBX, '0, 0);
    drv_r(1, 1, 0, 1, 1, LMBX, 16'h7E7E, 0); step(1);
    idle(); cur_req = "R5";
    drv_l(1, 0, 1, 1, 1, LMBX, '0, 0); step(1);
    idle(); step(2);

    chk_on = 0;
    finish_run();
  end
endmodule